// File: doc/BRIEF.md
# Multiplexed Host-Bus Access Sequencer

This block drives single accesses for one chip select on an external bus whose address and data share the same wires. Every access opens with a one-cycle address phase, in which the address is driven and an address-latch strobe is pulsed. A data phase follows with a read or write strobe. One hold cycle with both strobes idle comes next. The chip select then returns high. A requester hands accesses in over a request/acknowledge port, and a small register port sets the timing options.

The write strobe length is set in steps of two bus clocks. A trim bit shortens it by one clock, and a burst-mode bit forces the short fixed length. The latch-strobe polarity can be selected. Two start bits in the control register launch accesses to the configuration register of an attached pseudo-static RAM: a write of a stored 16-bit value, or a read whose result lands in a holding register. During these accesses a configuration-enable pin is raised. Each start bit clears itself on the clock edge where its access ends.

Top module: `hbseq_top`

## Requirements
- R1: After reset, bus_cs_n, bus_wr_n and bus_rd_n are 1, bus_ale is 0, acc_ack is 0, bus_ad_oe is 0, and the control register (register address 0) reads 0x1.
- R2: An access takes the following cycles in order. Chip select goes low. There is exactly one address cycle with the latch strobe active and the access address on bus_ad_o with bus_ad_oe high. The data phase follows, with write data on bus_ad_o[15:0] while bus_wr_n is low. One hold cycle with chip select low and both strobes high comes next. Then chip select returns high, and acc_ack is 1 for that single cycle.
- R3: Control register bits [2:1] hold a wait code w. With trim and burst clear, bus_wr_n stays low for 2*(w+1) consecutive clocks. The address phase stays at one clock for every w.
- R4: Control bit [3] (trim) shortens the write strobe by exactly one clock, to 2*(w+1)-1.
- R5: Control bit [4] (burst) sets the write strobe to 2 clocks, whatever w and trim hold.
- R6: Control bit [0] sets the latch polarity. With 1, bus_ale is 1 in the address cycle and 0 otherwise. With 0, it is 0 in the address cycle and 1 otherwise.
- R7: A read holds bus_rd_n low for 2 clocks. It samples bus_ad_i on the last of those clocks and presents that value on acc_rdata while acc_ack is 1.
- R8: Setting control bit [5] starts a configuration write with bus_cre high. The address is register 1 bits [17:16], zero-extended, and the data is register 1 bits [15:0]. The write strobe length follows R3 to R5. The bit reads 0 from the cycle in which chip select returns high, and acc_ack stays 0.
- R9: Setting control bit [6] starts a configuration read with bus_cre high, at the address in register 1 bits [17:16]. The 2-clock read strobe follows R7. The sampled data reads back from register address 2 bits [15:0]. The bit reads 0 from the cycle in which chip select returns high.
- R10: With bits [5] and [6] both set, the configuration write runs first and the configuration read runs after it.
- R11: A pending configuration start bit is served before a request waiting on the access port. The request is served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 control, 1 configuration value/address, 2 configuration read data) |
| reg_wdata | input | 18 | Register write data |
| reg_rdata | output | 18 | Register read data for reg_addr (combinational) |
| acc_req | input | 1 | Access request, held until acknowledged |
| acc_we | input | 1 | 1 for write, 0 for read |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | 16 | Write data |
| acc_ack | output | 1 | One-cycle completion pulse |
| acc_rdata | output | 16 | Read data, valid with acc_ack |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address-latch strobe, polarity per R6 |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_cre | output | 1 | Configuration-register enable for the RAM |
| bus_ad_o | output | ADDR_W | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Output enable for bus_ad_o |
| bus_ad_i | input | 16 | Data in from the bus |

## Verification
Writes are swept over every combination of wait code, trim, burst and latch polarity. Strobe-active clocks are counted in each case, which separates the base step of two from the one-clock trim and from the burst override, and shows that the address phase never stretches. Reads under both polarities use address-dependent bus data, so a sample taken one clock early or late shows up. The configuration tests run each start bit alone, then both bits together with an access request waiting. This exposes the service order, and the bench checks that each start bit reads back 0 in exactly the cycle in which chip select rises.

// File: rtl/hbseq_pkg.sv
package hbseq_pkg;

    localparam int HB_WS_W      = 2;
    localparam int HB_CFGA_W    = 2;
    localparam int HB_DATA_W    = 16;
    localparam int HB_REG_AW    = 2;
    localparam int HB_REG_DW    = HB_DATA_W + HB_CFGA_W;
    localparam int HB_RD_LEN    = 2;
    localparam int HB_BURST_LEN = 2;
    localparam int HB_MAX_STROBE = 2 * (1 << HB_WS_W);
    localparam int HB_CNT_W     = $clog2(HB_MAX_STROBE + 1);

    localparam logic [HB_REG_AW-1:0] HB_RA_CTRL  = 2'd0;
    localparam logic [HB_REG_AW-1:0] HB_RA_CFG   = 2'd1;
    localparam logic [HB_REG_AW-1:0] HB_RA_CFGRD = 2'd2;

    typedef struct packed {
        logic               rd_go;
        logic               wr_go;
        logic               burst;
        logic               trim;
        logic [HB_WS_W-1:0] ws;
        logic               latch_hi;
    } hb_ctrl_t;

    localparam int HB_CTRL_W = $bits(hb_ctrl_t);
    localparam hb_ctrl_t HB_CTRL_RST = '{rd_go: 1'b0, wr_go: 1'b0, burst: 1'b0,
                                         trim: 1'b0, ws: '0, latch_hi: 1'b1};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_HOLD
    } hb_state_e;

    typedef enum logic [1:0] {
        K_NORM,
        K_CFGW,
        K_CFGR
    } hb_kind_e;

endpackage

// File: rtl/hbseq_regs.sv
module hbseq_regs
    import hbseq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [HB_REG_AW-1:0]  reg_addr,
    input  logic [HB_REG_DW-1:0]  reg_wdata,
    output logic [HB_REG_DW-1:0]  reg_rdata,
    input  logic                  clr_wr_go,
    input  logic                  clr_rd_go,
    input  logic                  cfgrd_load,
    input  logic [HB_DATA_W-1:0]  cfgrd_data,
    output hb_ctrl_t              ctrl,
    output logic [HB_DATA_W-1:0]  cfg_val,
    output logic [HB_CFGA_W-1:0]  cfg_sel
);

    typedef struct packed {
        hb_ctrl_t              ctrl;
        logic [HB_DATA_W-1:0]  cfg_val;
        logic [HB_CFGA_W-1:0]  cfg_sel;
        logic [HB_DATA_W-1:0]  cfgrd;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                HB_RA_CTRL: r_d.ctrl = hb_ctrl_t'(reg_wdata[HB_CTRL_W-1:0]);
                HB_RA_CFG: begin
                    r_d.cfg_val = reg_wdata[HB_DATA_W-1:0];
                    r_d.cfg_sel = reg_wdata[HB_REG_DW-1:HB_DATA_W];
                end
                default: ;
            endcase
        end
        // completion of a configuration access wins over a same-cycle write
        if (clr_wr_go) r_d.ctrl.wr_go = 1'b0;
        if (clr_rd_go) r_d.ctrl.rd_go = 1'b0;
        if (cfgrd_load) r_d.cfgrd = cfgrd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl    <= HB_CTRL_RST;
            r_q.cfg_val <= '0;
            r_q.cfg_sel <= '0;
            r_q.cfgrd   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            HB_RA_CTRL:  reg_rdata = HB_REG_DW'(r_q.ctrl);
            HB_RA_CFG:   reg_rdata = {r_q.cfg_sel, r_q.cfg_val};
            HB_RA_CFGRD: reg_rdata = HB_REG_DW'(r_q.cfgrd);
            default:     reg_rdata = '0;
        endcase
    end

    assign ctrl    = r_q.ctrl;
    assign cfg_val = r_q.cfg_val;
    assign cfg_sel = r_q.cfg_sel;

    // R1: control register holds its reset pattern in the first cycle after reset
    a_r1_ctrl_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (r_q.ctrl == HB_CTRL_RST));

endmodule

// File: rtl/hbseq_strobe_len.sv
module hbseq_strobe_len
    import hbseq_pkg::*;
(
    input  logic [HB_WS_W-1:0]  ws,
    input  logic                trim,
    input  logic                burst,
    output logic [HB_CNT_W-1:0] wr_len
);

    int base_len;

    always_comb begin
        base_len = (int'(ws) + 1) * 2;
        if (burst) begin
            wr_len = HB_CNT_W'(HB_BURST_LEN);
        end else begin
            wr_len = HB_CNT_W'(base_len - int'(trim));
        end
    end

endmodule

// File: rtl/hbseq_seq.sv
module hbseq_seq
    import hbseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  hb_ctrl_t              ctrl,
    input  logic [HB_DATA_W-1:0]  cfg_val,
    input  logic [HB_CFGA_W-1:0]  cfg_sel,
    input  logic [HB_CNT_W-1:0]   wr_len,
    input  logic                  acc_req,
    input  logic                  acc_we,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [HB_DATA_W-1:0]  acc_wdata,
    output logic                  acc_ack,
    output logic [HB_DATA_W-1:0]  acc_rdata,
    output logic                  clr_wr_go,
    output logic                  clr_rd_go,
    output logic                  cfgrd_load,
    output logic [HB_DATA_W-1:0]  cfgrd_data,
    output logic                  bus_cs_n,
    output logic                  bus_ale,
    output logic                  bus_wr_n,
    output logic                  bus_rd_n,
    output logic                  bus_cre,
    output logic [ADDR_W-1:0]     bus_ad_o,
    output logic                  bus_ad_oe,
    input  logic [HB_DATA_W-1:0]  bus_ad_i
);

    typedef struct packed {
        hb_state_e             st;
        hb_kind_e              kind;
        logic                  is_wr;
        logic [ADDR_W-1:0]     addr;
        logic [HB_DATA_W-1:0]  wdata;
        logic [HB_CNT_W-1:0]   cnt;
        logic                  ack;
        logic [HB_DATA_W-1:0]  rdata;
    } seq_t;

    seq_t s_d, s_q;

    logic in_addr, in_data;

    always_comb begin
        s_d        = s_q;
        s_d.ack    = 1'b0;
        clr_wr_go  = 1'b0;
        clr_rd_go  = 1'b0;
        cfgrd_load = 1'b0;
        cfgrd_data = bus_ad_i;
        case (s_q.st)
            ST_IDLE: begin
                if (!s_q.ack) begin
                    if (ctrl.wr_go) begin
                        s_d.st    = ST_ADDR;
                        s_d.kind  = K_CFGW;
                        s_d.is_wr = 1'b1;
                        s_d.addr  = ADDR_W'(cfg_sel);
                        s_d.wdata = cfg_val;
                    end else if (ctrl.rd_go) begin
                        s_d.st    = ST_ADDR;
                        s_d.kind  = K_CFGR;
                        s_d.is_wr = 1'b0;
                        s_d.addr  = ADDR_W'(cfg_sel);
                    end else if (acc_req) begin
                        s_d.st    = ST_ADDR;
                        s_d.kind  = K_NORM;
                        s_d.is_wr = acc_we;
                        s_d.addr  = acc_addr;
                        s_d.wdata = acc_wdata;
                    end
                end
            end
            ST_ADDR: begin
                s_d.st  = ST_DATA;
                s_d.cnt = s_q.is_wr ? (wr_len - HB_CNT_W'(1)) : HB_CNT_W'(HB_RD_LEN - 1);
            end
            ST_DATA: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_HOLD;
                    if (!s_q.is_wr) begin
                        if (s_q.kind == K_CFGR) cfgrd_load = 1'b1;
                        else                    s_d.rdata  = bus_ad_i;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - HB_CNT_W'(1);
                end
            end
            ST_HOLD: begin
                s_d.st = ST_IDLE;
                case (s_q.kind)
                    K_CFGW:  clr_wr_go = 1'b1;
                    K_CFGR:  clr_rd_go = 1'b1;
                    default: s_d.ack   = 1'b1;
                endcase
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.kind  <= K_NORM;
            s_q.is_wr <= 1'b0;
            s_q.addr  <= '0;
            s_q.wdata <= '0;
            s_q.cnt   <= '0;
            s_q.ack   <= 1'b0;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_addr   = (s_q.st == ST_ADDR);
    assign in_data   = (s_q.st == ST_DATA);
    assign bus_cs_n  = (s_q.st == ST_IDLE);
    assign bus_ale   = ctrl.latch_hi ? in_addr : !in_addr;
    assign bus_wr_n  = !(in_data && s_q.is_wr);
    assign bus_rd_n  = !(in_data && !s_q.is_wr);
    assign bus_cre   = (s_q.st != ST_IDLE) && (s_q.kind != K_NORM);
    assign bus_ad_o  = in_addr ? s_q.addr : ADDR_W'(s_q.wdata);
    assign bus_ad_oe = in_addr || (s_q.is_wr && (in_data || s_q.st == ST_HOLD));
    assign acc_ack   = s_q.ack;
    assign acc_rdata = s_q.rdata;

    // strobe run-length monitor for the assertions below
    logic [HB_CNT_W:0] wr_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         wr_run_q <= '0;
        else if (!bus_wr_n) wr_run_q <= wr_run_q + 1'b1;
        else                wr_run_q <= '0;
    end

    // R3: the write strobe never outlasts the longest encodable wait time
    a_r3_strobe_max: assert property (@(posedge clk) disable iff (!rst_n)
        wr_run_q <= (HB_CNT_W + 1)'(HB_MAX_STROBE));

    // R2: acknowledge only after a cycle with chip select low and both strobes idle
    a_r2_ack_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |-> (bus_cs_n && $past(!bus_cs_n && bus_wr_n && bus_rd_n)));

    // R2: the first cycle of chip select carries the latch strobe at its active level
    a_r6_latch_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> (bus_ale == ctrl.latch_hi));

    // R7: read and write strobes never overlap
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_wr_n && !bus_rd_n));

    // R1: with chip select high the bus is quiet
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> (bus_wr_n && bus_rd_n && !bus_ad_oe && !bus_cre));

endmodule

// File: rtl/hbseq_top.sv
module hbseq_top
    import hbseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [HB_REG_AW-1:0]  reg_addr,
    input  logic [HB_REG_DW-1:0]  reg_wdata,
    output logic [HB_REG_DW-1:0]  reg_rdata,
    input  logic                  acc_req,
    input  logic                  acc_we,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [HB_DATA_W-1:0]  acc_wdata,
    output logic                  acc_ack,
    output logic [HB_DATA_W-1:0]  acc_rdata,
    output logic                  bus_cs_n,
    output logic                  bus_ale,
    output logic                  bus_wr_n,
    output logic                  bus_rd_n,
    output logic                  bus_cre,
    output logic [ADDR_W-1:0]     bus_ad_o,
    output logic                  bus_ad_oe,
    input  logic [HB_DATA_W-1:0]  bus_ad_i
);

    hb_ctrl_t              ctrl;
    logic [HB_DATA_W-1:0]  cfg_val;
    logic [HB_CFGA_W-1:0]  cfg_sel;
    logic [HB_CNT_W-1:0]   wr_len;
    logic                  clr_wr_go, clr_rd_go, cfgrd_load;
    logic [HB_DATA_W-1:0]  cfgrd_data;

    hbseq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .clr_wr_go  (clr_wr_go),
        .clr_rd_go  (clr_rd_go),
        .cfgrd_load (cfgrd_load),
        .cfgrd_data (cfgrd_data),
        .ctrl       (ctrl),
        .cfg_val    (cfg_val),
        .cfg_sel    (cfg_sel)
    );

    hbseq_strobe_len u_len (
        .ws     (ctrl.ws),
        .trim   (ctrl.trim),
        .burst  (ctrl.burst),
        .wr_len (wr_len)
    );

    hbseq_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .cfg_val    (cfg_val),
        .cfg_sel    (cfg_sel),
        .wr_len     (wr_len),
        .acc_req    (acc_req),
        .acc_we     (acc_we),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .acc_ack    (acc_ack),
        .acc_rdata  (acc_rdata),
        .clr_wr_go  (clr_wr_go),
        .clr_rd_go  (clr_rd_go),
        .cfgrd_load (cfgrd_load),
        .cfgrd_data (cfgrd_data),
        .bus_cs_n   (bus_cs_n),
        .bus_ale    (bus_ale),
        .bus_wr_n   (bus_wr_n),
        .bus_rd_n   (bus_rd_n),
        .bus_cre    (bus_cre),
        .bus_ad_o   (bus_ad_o),
        .bus_ad_oe  (bus_ad_oe),
        .bus_ad_i   (bus_ad_i)
    );

    // R8: the write start bit drops on the edge where chip select returns high
    a_r8_wr_go_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl.wr_go) && !$past(reg_we)) |-> $rose(bus_cs_n));

    // R9: the read start bit drops on the edge where chip select returns high
    a_r9_rd_go_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl.rd_go) && !$past(reg_we)) |-> $rose(bus_cs_n));

    // R8: configuration accesses never acknowledge on the access port
    a_r8_cfg_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cre && !bus_cs_n) |=> !acc_ack);

endmodule

// File: tb/hbseq_top_tb_top.sv
`timescale 1ns/1ps
module hbseq_top_tb_top;
    import hbseq_pkg::*;

    localparam int AW = 20;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 reg_we = 1'b0;
    logic [HB_REG_AW-1:0] reg_addr = '0;
    logic [HB_REG_DW-1:0] reg_wdata = '0;
    logic [HB_REG_DW-1:0] reg_rdata;
    logic                 acc_req = 1'b0;
    logic                 acc_we = 1'b0;
    logic [AW-1:0]        acc_addr = '0;
    logic [15:0]          acc_wdata = '0;
    logic                 acc_ack;
    logic [15:0]          acc_rdata;
    logic                 bus_cs_n, bus_ale, bus_wr_n, bus_rd_n, bus_cre, bus_ad_oe;
    logic [AW-1:0]        bus_ad_o;
    logic [15:0]          bus_ad_i;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    bit  cur_pol = 1'b1;
    logic [AW-1:0] lat = '0;

    always #10 clk = ~clk;

    hbseq_top #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_req(acc_req),
        .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_ack(acc_ack), .acc_rdata(acc_rdata), .bus_cs_n(bus_cs_n),
        .bus_ale(bus_ale), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .bus_cre(bus_cre), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
        .bus_ad_i(bus_ad_i)
    );

    // bus-side memory model: data depends on the latched address
    always @(negedge clk) if (!bus_cs_n && bus_ale == cur_pol) lat <= bus_ad_o;
    assign bus_ad_i = lat[15:0] ^ 16'hC3A5;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [HB_REG_DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0;
        #1;
    endtask

    // watch one chip-select episode; returns at the first negedge with cs_n high again
    task automatic observe(output int n_ale, output int n_wr, output int n_rd,
                           output int n_hold, output int n_early_ack, output bit cre,
                           output logic [AW-1:0] a, output logic [15:0] wd,
                           output bit ackd, output logic [15:0] rdv,
                           output logic [HB_REG_DW-1:0] ctrl_before,
                           output logic [HB_REG_DW-1:0] ctrl_end, output bit ale_idle);
        bit started = 1'b0;
        n_ale = 0; n_wr = 0; n_rd = 0; n_hold = 0; n_early_ack = 0; cre = 1'b0;
        a = '0; wd = '0; ackd = 1'b0; rdv = '0; ctrl_before = '0; ctrl_end = '0; ale_idle = 1'b0;
        for (int g = 0; g < 200; g++) begin
            @(negedge clk);
            if (!bus_cs_n) begin
                started = 1'b1;
                if (bus_ale == cur_pol) begin n_ale++; a = bus_ad_o; end
                if (!bus_wr_n) begin n_wr++; wd = bus_ad_o[15:0]; end
                if (!bus_rd_n) n_rd++;
                if (bus_wr_n && bus_rd_n && bus_ale != cur_pol && (n_wr + n_rd) > 0) n_hold++;
                if (acc_ack) n_early_ack++;
                if (bus_cre) cre = 1'b1;
                ctrl_before = reg_rdata;
            end else if (started) begin
                ackd = acc_ack; rdv = acc_rdata; ctrl_end = reg_rdata;
                ale_idle = (bus_ale == !cur_pol);
                return;
            end
        end
    endtask

    int n_ale, n_wr, n_rd, n_hold, n_early;
    bit cre, ackd, ale_idle;
    logic [AW-1:0] a_seen;
    logic [15:0] wd_seen, rd_seen;
    logic [HB_REG_DW-1:0] cb, ce;

    task automatic do_access(input bit we, input logic [AW-1:0] ad, input logic [15:0] wd);
        @(negedge clk);
        acc_req = 1'b1; acc_we = we; acc_addr = ad; acc_wdata = wd;
        observe(n_ale, n_wr, n_rd, n_hold, n_early, cre, a_seen, wd_seen, ackd,
                rd_seen, cb, ce, ale_idle);
        acc_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(bus_cs_n == 1 && bus_wr_n == 1 && bus_rd_n == 1, "R1 strobes idle",
            {bus_cs_n, bus_wr_n, bus_rd_n}, 3'b111);
        chk(bus_ale == 0 && acc_ack == 0 && bus_ad_oe == 0, "R1 ale/ack/oe",
            {bus_ale, acc_ack, bus_ad_oe}, 0);
        chk(reg_rdata == 18'h1, "R1 ctrl reset", reg_rdata, 1);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3/R4/R5/R6/R2: sweep of write timing options
        for (int pol = 0; pol < 2; pol++)
            for (int bu = 0; bu < 2; bu++)
                for (int tr = 0; tr < 2; tr++)
                    for (int ws = 0; ws < 4; ws++) begin
                        int exp_len;
                        logic [AW-1:0] ad;
                        logic [15:0] wd;
                        string tag;
                        ad = AW'(20'h1_2340 + (pol * 16 + bu * 8 + tr * 4 + ws) * 20'h111);
                        wd = 16'h5A00 ^ 16'(pol * 16 + bu * 8 + tr * 4 + ws);
                        exp_len = bu ? 2 : 2 * (ws + 1) - tr;
                        tag = bu ? "R5 burst length" : (tr ? "R4 trimmed length" : "R3 wait length");
                        cur_pol = pol[0];
                        reg_write(HB_RA_CTRL, HB_REG_DW'(pol | (ws << 1) | (tr << 3) | (bu << 4)));
                        do_access(1'b1, ad, wd);
                        chk(n_wr == exp_len, tag, n_wr, exp_len);
                        chk(n_ale == 1, "R6 one address cycle at active level", n_ale, 1);
                        chk(ale_idle, "R6 idle latch level", bus_ale, !cur_pol);
                        chk(a_seen == ad, "R2 address on bus", a_seen, ad);
                        chk(wd_seen == wd, "R2 write data on bus", wd_seen, wd);
                        chk(n_hold == 1, "R2 one hold cycle", n_hold, 1);
                        chk(ackd && n_early == 0, "R2 ack at end only", {ackd, n_early[7:0]}, 9'h100);
                        chk(!cre, "R2 no cre on normal access", cre, 0);
                    end

        // R7: reads under both polarities
        for (int pol = 0; pol < 2; pol++) begin
            logic [AW-1:0] ad;
            ad = AW'(20'hA_BC00 + pol * 20'h35);
            cur_pol = pol[0];
            reg_write(HB_RA_CTRL, HB_REG_DW'(pol | (3 << 1)));
            do_access(1'b0, ad, 16'h0);
            chk(n_rd == 2, "R7 read strobe length", n_rd, 2);
            chk(n_wr == 0, "R7 no write strobe", n_wr, 0);
            chk(ackd && rd_seen == (ad[15:0] ^ 16'hC3A5), "R7 read data", rd_seen, ad[15:0] ^ 16'hC3A5);
            chk(n_hold == 1, "R7 hold after read", n_hold, 1);
        end

        // R8: configuration write
        cur_pol = 1'b1;
        reg_write(HB_RA_CFG, {2'd2, 16'hBEEF});
        reg_write(HB_RA_CTRL, 18'h23);
        observe(n_ale, n_wr, n_rd, n_hold, n_early, cre, a_seen, wd_seen, ackd, rd_seen, cb, ce, ale_idle);
        chk(cre && a_seen == 20'd2, "R8 cfg write address", a_seen, 2);
        chk(wd_seen == 16'hBEEF, "R8 cfg write data", wd_seen, 16'hBEEF);
        chk(n_wr == 4, "R8 cfg write strobe length", n_wr, 4);
        chk(cb[5] == 1'b1 && ce[5] == 1'b0, "R8 start bit clears at end", {cb[5], ce[5]}, 2'b10);
        chk(!ackd && n_early == 0, "R8 no access ack", ackd, 0);

        // R9: configuration read
        reg_write(HB_RA_CFG, {2'd3, 16'h0000});
        reg_write(HB_RA_CTRL, 18'h43);
        observe(n_ale, n_wr, n_rd, n_hold, n_early, cre, a_seen, wd_seen, ackd, rd_seen, cb, ce, ale_idle);
        chk(cre && a_seen == 20'd3 && n_rd == 2, "R9 cfg read access", {a_seen, n_rd[3:0]}, {20'd3, 4'd2});
        chk(cb[6] == 1'b1 && ce[6] == 1'b0, "R9 start bit clears at end", {cb[6], ce[6]}, 2'b10);
        @(negedge clk); reg_addr = HB_RA_CFGRD; #1;
        chk(reg_rdata[15:0] == (16'h3 ^ 16'hC3A5), "R9 cfg read data", reg_rdata[15:0], 16'h3 ^ 16'hC3A5);
        reg_addr = HB_RA_CTRL;

        // R10/R11: both start bits plus a waiting request
        reg_write(HB_RA_CFG, {2'd1, 16'h1357});
        reg_write(HB_RA_CTRL, 18'h63);
        acc_req = 1'b1; acc_we = 1'b1; acc_addr = 20'h7_7770; acc_wdata = 16'h2468;
        observe(n_ale, n_wr, n_rd, n_hold, n_early, cre, a_seen, wd_seen, ackd, rd_seen, cb, ce, ale_idle);
        chk(cre && n_wr == 4 && wd_seen == 16'h1357, "R10 write served first", n_wr, 4);
        chk(ce[5] == 1'b0 && ce[6] == 1'b1, "R10 read still pending", ce[6:5], 2'b10);
        observe(n_ale, n_wr, n_rd, n_hold, n_early, cre, a_seen, wd_seen, ackd, rd_seen, cb, ce, ale_idle);
        chk(cre && n_rd == 2 && a_seen == 20'd1, "R10 read served second", n_rd, 2);
        chk(ce[6:5] == 2'b00 && !ackd, "R11 request still waiting", {ce[6:5], ackd}, 0);
        observe(n_ale, n_wr, n_rd, n_hold, n_early, cre, a_seen, wd_seen, ackd, rd_seen, cb, ce, ale_idle);
        acc_req = 1'b0;
        chk(!cre && ackd && a_seen == 20'h7_7770, "R11 request served after cfg", a_seen, 20'h7_7770);
        chk(wd_seen == 16'h2468 && n_wr == 4, "R11 request write data", wd_seen, 16'h2468);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule